// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Store Controller

This block sits on the I/O register bus of a small processor and gives software byte access to a 512-byte nonvolatile data store. Software loads a 9-bit byte address into a pair of address registers, places a byte in a data register, and then uses a control register to start a store or a fetch. The store array is modelled inside the block as a 512x8 memory written so that block RAM can be inferred.

Stores are guarded: a store strobe only takes effect if an arming bit was set in an earlier bus write and has not yet timed out. A started store holds the processor for a short fixed time, writes the byte, and then keeps a pollable busy bit set for a long, parameterised programming time. Fetches hold the processor for a different fixed time while the byte is moved into the data register. While a store is still programming, further store or fetch strobes are dropped.

Top module: `nvm_access_ctrl`

## Requirements
- R1: Register map on the 6-bit I/O address: control at 0x1C, data at 0x1D, address low byte at 0x1E, address high at 0x1F. A read with `io_rd_en` presents the register value on `io_rd_data` from the next cycle, and that value is the register state at the cycle of the request.
- R2: The byte address is {high[0], low[7:0]}. Bits 7..1 of the address high register and bits 7..3 of the control register always read as zero.
- R3: After reset every register reads zero, the busy bit is clear and `cpu_stall` is low.
- R4: Writing control bit 2 (arm) as 1 sets the arm bit; it reads 1 for exactly 4 cycles after that write and then clears itself.
- R5: A control write with bit 1 set, while the arm bit is already set and no store is in progress, stores the data register into the byte at the current address; control bit 1 then reads 1 for WR_DELAY_CYC cycles and clears itself.
- R6: A started store drives `cpu_stall` high for exactly 2 cycles, starting the cycle after the control write.
- R7: A control write with bit 0 set, when no store is in progress, drives `cpu_stall` high for exactly 4 cycles and loads the data register with the stored byte at the current address; bit 0 reads 1 until that load.
- R8: A store strobe without the arm bit already set, including arm and strobe in the same write (0x06) or a strobe after the arm bit has timed out, writes nothing, does not set the busy bit and does not stall.
- R9: While a store is in progress, fetch and store strobes are ignored: no stall, the data register keeps its value, and the store array is unchanged.
- R10: Addresses differing only in bit 8 select distinct bytes across the whole 512-byte space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | I/O register address |
| io_wr_en | input | 1 | Register write strobe |
| io_wr_data | input | 8 | Register write data |
| io_rd_en | input | 1 | Register read strobe |
| io_rd_data | output | 8 | Registered register read data |
| cpu_stall | output | 1 | Processor hold request |

## Verification
A register read returns the state of the cycle in which it was requested and is sampled one cycle later; the bench therefore polls the control register at exact cycle offsets from a strobe, expecting the arm bit to read 1 at offsets 0 and 3 and 0 at offset 4, and the busy bit to read 1 at offset WR_DELAY_CYC-1 and 0 at WR_DELAY_CYC. The stall output is due on the first falling edge after the strobe edge and is sampled on each falling edge, so a store must show 1,1,0 and a fetch 1,1,1,1,0. Fetched bytes are compared only after the four stall cycles, when the data register load (two edges after the strobe) is complete, against a bench model of the array filled by directed and seeded random stores.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int REG_CTRL  = 'h1C;
  localparam int REG_DATA  = 'h1D;
  localparam int REG_ADDRL = 'h1E;
  localparam int REG_ADDRH = 'h1F;

  localparam int CTRL_RD_BIT  = 0;
  localparam int CTRL_WR_BIT  = 1;
  localparam int CTRL_ARM_BIT = 2;
endpackage

// File: rtl/nvm_timer.sv
module nvm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             active
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= (load_val != '0);
    end else if (cnt != '0) begin
      cnt    <= cnt - 1'b1;
      active <= (cnt > CNT_W'(1));
    end
  end
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end else if (re) begin
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int IO_AW        = 6,
  parameter int WR_DELAY_CYC = 200,
  parameter int WR_STALL_CYC = 2,
  parameter int RD_STALL_CYC = 4,
  parameter int ARM_HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr_en,
  input  logic [DATA_W-1:0] io_wr_data,
  input  logic              io_rd_en,
  output logic [DATA_W-1:0] io_rd_data,
  output logic              cpu_stall
);
  localparam int HI_W      = ADDR_W - DATA_W;
  localparam int WR_CNT_W  = $clog2(WR_DELAY_CYC + 1);
  localparam int ARM_CNT_W = $clog2(ARM_HOLD_CYC + 1);
  localparam int STALL_MAX = (WR_STALL_CYC > RD_STALL_CYC) ? WR_STALL_CYC : RD_STALL_CYC;
  localparam int STL_CNT_W = $clog2(STALL_MAX + 1);

  logic [DATA_W-1:0] addr_lo;
  logic [HI_W-1:0]   addr_hi;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] nvm_addr;
  logic [DATA_W-1:0] store_q;
  logic [DATA_W-1:0] ctrl_view;

  logic sel_ctrl_w, sel_data_w, sel_lo_w, sel_hi_w;
  logic arm_on, wr_busy;
  logic arm_go, wr_go, rd_go;
  logic rd_s1, rd_s2, rd_pend;

  assign nvm_addr = {addr_hi, addr_lo};

  // bus write decode
  assign sel_ctrl_w = io_wr_en && (io_addr == IO_AW'(REG_CTRL));
  assign sel_data_w = io_wr_en && (io_addr == IO_AW'(REG_DATA));
  assign sel_lo_w   = io_wr_en && (io_addr == IO_AW'(REG_ADDRL));
  assign sel_hi_w   = io_wr_en && (io_addr == IO_AW'(REG_ADDRH));

  // access sequencing: a store needs an arm set in an earlier cycle
  assign arm_go  = sel_ctrl_w && io_wr_data[CTRL_ARM_BIT];
  assign wr_go   = sel_ctrl_w && io_wr_data[CTRL_WR_BIT] && arm_on && !wr_busy;
  assign rd_go   = sel_ctrl_w && io_wr_data[CTRL_RD_BIT] && !wr_busy && !wr_go && !rd_pend;
  assign rd_pend = rd_s1 || rd_s2;

  nvm_timer #(.CNT_W(ARM_CNT_W)) arm_tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (arm_go),
    .load_val (ARM_CNT_W'(ARM_HOLD_CYC)),
    .active   (arm_on)
  );

  nvm_timer #(.CNT_W(WR_CNT_W)) prog_tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_go),
    .load_val (WR_CNT_W'(WR_DELAY_CYC)),
    .active   (wr_busy)
  );

  nvm_timer #(.CNT_W(STL_CNT_W)) stall_tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_go || rd_go),
    .load_val (wr_go ? STL_CNT_W'(WR_STALL_CYC) : STL_CNT_W'(RD_STALL_CYC)),
    .active   (cpu_stall)
  );

  nvm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk   (clk),
    .we    (wr_go),
    .re    (rd_s1),
    .addr  (nvm_addr),
    .wdata (data_q),
    .q     (store_q)
  );

  // fetch pipeline: strobe -> array read -> data register load
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s1 <= 1'b0;
      rd_s2 <= 1'b0;
    end else begin
      rd_s1 <= rd_go;
      rd_s2 <= rd_s1;
    end
  end

  // address and data registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo <= '0;
      addr_hi <= '0;
      data_q  <= '0;
    end else begin
      if (sel_lo_w) addr_lo <= io_wr_data;
      if (sel_hi_w) addr_hi <= io_wr_data[HI_W-1:0];
      if (rd_s2)
        data_q <= store_q;
      else if (sel_data_w)
        data_q <= io_wr_data;
    end
  end

  always_comb begin
    ctrl_view               = '0;
    ctrl_view[CTRL_ARM_BIT] = arm_on;
    ctrl_view[CTRL_WR_BIT]  = wr_busy;
    ctrl_view[CTRL_RD_BIT]  = rd_pend;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      io_rd_data <= '0;
    end else if (io_rd_en) begin
      case (io_addr)
        IO_AW'(REG_CTRL):  io_rd_data <= ctrl_view;
        IO_AW'(REG_DATA):  io_rd_data <= data_q;
        IO_AW'(REG_ADDRL): io_rd_data <= addr_lo;
        IO_AW'(REG_ADDRH): io_rd_data <= DATA_W'(addr_hi);
        default:           io_rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/nvm_access_chk.sv
module nvm_access_chk
  import nvm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IO_AW  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_wr_en,
  input logic [DATA_W-1:0] io_wr_data,
  input logic              io_rd_en,
  input logic [DATA_W-1:0] io_rd_data,
  input logic              cpu_stall,
  input logic              arm_on,
  input logic              wr_busy,
  input logic              rd_pend
);
  logic ctrl_w;
  assign ctrl_w = io_wr_en && (io_addr == IO_AW'(REG_CTRL));

  assert_addrh_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    (io_rd_en && io_addr == IO_AW'(REG_ADDRH)) |=> (io_rd_data[DATA_W-1:1] == '0));

  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    (io_rd_en && io_addr == IO_AW'(REG_CTRL)) |=> (io_rd_data[DATA_W-1:3] == '0));

  assert_arm_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && io_wr_data[CTRL_ARM_BIT]) |=> arm_on ##1 arm_on ##1 arm_on);

  assert_store_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && io_wr_data[CTRL_WR_BIT] && arm_on && !wr_busy)
      |=> cpu_stall ##1 cpu_stall ##1 !cpu_stall);

  assert_fetch_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && io_wr_data[CTRL_RD_BIT] && !rd_pend && !wr_busy
       && !(io_wr_data[CTRL_WR_BIT] && arm_on))
      |=> cpu_stall ##1 cpu_stall ##1 cpu_stall ##1 cpu_stall ##1 !cpu_stall);

  assert_guard_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(arm_on));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && io_wr_data[CTRL_RD_BIT] && wr_busy) |=> !rd_pend);
endmodule

bind nvm_access_ctrl nvm_access_chk #(.DATA_W(DATA_W), .IO_AW(IO_AW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .io_addr    (io_addr),
  .io_wr_en   (io_wr_en),
  .io_wr_data (io_wr_data),
  .io_rd_en   (io_rd_en),
  .io_rd_data (io_rd_data),
  .cpu_stall  (cpu_stall),
  .arm_on     (arm_on),
  .wr_busy    (wr_busy),
  .rd_pend    (rd_pend)
);

// File: tb/nvm_access_ctrl_tb_top.sv
module nvm_access_ctrl_tb_top;
  localparam int D = 40;
  localparam int A_CTRL = 'h1C, A_DATA = 'h1D, A_LO = 'h1E, A_HI = 'h1F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] io_addr = '0;
  logic       io_wr_en = 1'b0;
  logic [7:0] io_wr_data = '0;
  logic       io_rd_en = 1'b0;
  logic [7:0] io_rd_data;
  logic       cpu_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] model [512];
  bit         known [512];

  always #10 clk = ~clk;

  nvm_access_ctrl #(.WR_DELAY_CYC(D)) dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr_en(io_wr_en),
    .io_wr_data(io_wr_data), .io_rd_en(io_rd_en), .io_rd_data(io_rd_data),
    .cpu_stall(cpu_stall)
  );

  function automatic int ctrl_exp(bit arm, bit busy, bit rdp);
    return (int'(arm) << 2) | (int'(busy) << 1) | int'(rdp);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at a falling edge
  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic io_write(int a, int v);
    io_addr = 6'(a); io_wr_data = 8'(v); io_wr_en = 1'b1;
    @(negedge clk);
    io_wr_en = 1'b0;
  endtask

  // returns the register state at the cycle of the call
  task automatic io_read(int a, output int v);
    io_addr = 6'(a); io_rd_en = 1'b1;
    @(negedge clk);
    io_rd_en = 1'b0;
    v = int'(io_rd_data);
  endtask

  task automatic set_addr(int a);
    io_write(A_LO, a & 'hFF);
    io_write(A_HI, (a >> 8) & 'h1);
  endtask

  task automatic do_store(int a, int v);
    set_addr(a);
    io_write(A_DATA, v);
    io_write(A_CTRL, 'h04);
    io_write(A_CTRL, 'h02);
    model[a] = 8'(v); known[a] = 1'b1;
    idle(D);
  endtask

  task automatic do_fetch(int a, output int v);
    set_addr(a);
    io_write(A_CTRL, 'h01);
    idle(4);
    io_read(A_DATA, v);
  endtask

  initial begin
    int v;
    int a, b;
    void'($urandom(32'd2718));
    idle(3);
    rst = 1'b0;

    // R3 reset state
    chk("R3 stall", int'(cpu_stall), 0);
    io_read(A_CTRL, v);  chk("R3 ctrl", v, 0);
    io_read(A_DATA, v);  chk("R3 data", v, 0);
    io_read(A_LO, v);    chk("R3 addr lo", v, 0);
    io_read(A_HI, v);    chk("R3 addr hi", v, 0);

    // R1 map, R2 reserved bits
    io_write(A_LO, 'hA5);   io_read(A_LO, v);   chk("R1 addr lo", v, 'hA5);
    io_write(A_DATA, 'h3C); io_read(A_DATA, v); chk("R1 data", v, 'h3C);
    io_write(A_HI, 'hFF);   io_read(A_HI, v);   chk("R2 addr hi reserved", v, 'h01);
    io_write(A_CTRL, 'hF8); io_read(A_CTRL, v); chk("R2 ctrl reserved", v, 0);

    // R4 arm lifetime: 1 at offsets 0..3, 0 at offset 4
    io_write(A_CTRL, 'h04);
    io_read(A_CTRL, v); chk("R4 arm offset0", v, ctrl_exp(1, 0, 0));
    idle(2);
    io_read(A_CTRL, v); chk("R4 arm offset3", v, ctrl_exp(1, 0, 0));
    io_read(A_CTRL, v); chk("R4 arm offset4", v, 0);

    // R5/R6 store with exact stall and busy timing
    set_addr('h0C3);
    io_write(A_DATA, 'h5A);
    io_write(A_CTRL, 'h04);
    io_write(A_CTRL, 'h02);
    model['h0C3] = 8'h5A; known['h0C3] = 1'b1;
    chk("R6 stall c0", int'(cpu_stall), 1);
    idle(1); chk("R6 stall c1", int'(cpu_stall), 1);
    idle(1); chk("R6 stall c2", int'(cpu_stall), 0);
    idle(D - 3);
    io_read(A_CTRL, v); chk("R5 busy last", v, ctrl_exp(0, 1, 0));
    io_read(A_CTRL, v); chk("R5 busy clear", v, 0);

    // R7 fetch timing and data load
    io_write(A_DATA, 'h00);
    io_write(A_CTRL, 'h01);
    chk("R7 stall c0", int'(cpu_stall), 1);
    io_read(A_CTRL, v); chk("R7 rd bit pending", v, ctrl_exp(0, 0, 1));
    idle(2); chk("R7 stall c3", int'(cpu_stall), 1);
    idle(1); chk("R7 stall c4", int'(cpu_stall), 0);
    io_read(A_DATA, v); chk("R7 fetched byte", v, 'h5A);
    io_read(A_CTRL, v); chk("R7 rd bit cleared", v, 0);

    // R8 guard: arm and strobe together, and strobe after arm expiry
    io_write(A_DATA, 'hEE);
    io_write(A_CTRL, 'h06);
    chk("R8 no stall same write", int'(cpu_stall), 0);
    io_read(A_CTRL, v); chk("R8 no busy same write", v, ctrl_exp(1, 0, 0));
    idle(5);
    io_write(A_CTRL, 'h02);
    chk("R8 no stall expired arm", int'(cpu_stall), 0);
    io_read(A_CTRL, v); chk("R8 no busy expired arm", v, 0);
    do_fetch('h0C3, v); chk("R8 array unchanged", v, 'h5A);

    // R10 bit 8 selects distinct bytes
    do_store('h005, 'h11);
    do_store('h105, 'h22);
    do_fetch('h005, v); chk("R10 low half", v, 'h11);
    do_fetch('h105, v); chk("R10 high half", v, 'h22);

    // R9 strobes ignored while programming
    set_addr('h0C3);
    io_write(A_DATA, 'h99);
    io_write(A_CTRL, 'h04);
    io_write(A_CTRL, 'h02);
    model['h0C3] = 8'h99;
    idle(2);
    io_write(A_DATA, 'h77);
    io_write(A_CTRL, 'h01);
    chk("R9 no fetch stall", int'(cpu_stall), 0);
    io_read(A_CTRL, v); chk("R9 fetch dropped", v, ctrl_exp(0, 1, 0));
    set_addr('h005);
    io_write(A_CTRL, 'h04);
    io_write(A_CTRL, 'h02);
    chk("R9 no store stall", int'(cpu_stall), 0);
    idle(D);
    io_read(A_DATA, v); chk("R9 data kept", v, 'h77);
    do_fetch('h005, v); chk("R9 array kept", v, 'h11);
    do_fetch('h0C3, v); chk("R5 first store landed", v, 'h99);

    // seeded random stores and fetches against the model
    for (int it = 0; it < 40; it++) begin
      a = int'($urandom() % 512);
      b = int'($urandom() % 256);
      if (known[a] && ($urandom() % 2 == 1)) begin
        do_fetch(a, v); chk("R7 random fetch", v, int'(model[a]));
      end else begin
        do_store(a, b);
        do_fetch(a, v); chk("R5 random store", v, b);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule